// File: doc/BRIEF.md
# Vector Table RAM with SECDED and Check-Bit Diagnostics

This block stores interrupt handler addresses as 32-bit words. Each word has its own 7-bit SECDED check field. Software reaches the memory through a single-port request interface with word addressing and one cycle of read latency. A data read decodes the syndrome. A single flipped bit in the data or check field is repaired in the returned word and flagged as correctable. Two flipped bits are flagged as uncorrectable, and the raw stored data is returned.

One high address bit, the alias bit, selects between the data words and their check fields. Reads of the check field are plain reads and never raise an error. A check field can be written only when both the diagnostic enable and the ECC enable are high. Turning ECC off lets software write data without updating its check field. Together these let a self-test place faults in the data or in the code independently.

The RAM contents are undefined after reset. A start pulse runs an engine that writes zero data, with matching check bits, to every word. The engine writes one word per clock and holds off the bus while it runs.

Top module: `vec_ecc_ram`

## Requirements
- R1: A read request with the alias bit (address bit 10) at 0 returns the addressed data word on rdata_o and pulses rvalid_o in the following cycle.
- R2: A read with the alias bit at 1 returns the stored check field in rdata_o[6:0], with bits 31:7 zero. corr_err_o and uncorr_err_o stay low, whatever ecc_en_i and diag_en_i are.
- R3: A data write (alias bit 0) with ecc_en_i high stores the data together with a freshly computed check field, so a later data read returns it with no error flag.
- R4: A data write with ecc_en_i low changes the data only and leaves the stored check field unchanged.
- R5: A write with the alias bit at 1 while diag_en_i and ecc_en_i are both high replaces the check field with wdata_i[6:0] and leaves the data unchanged.
- R6: A write with the alias bit at 1 and diag_en_i or ecc_en_i low changes nothing and pulses wr_rej_o for one cycle in the following cycle. wr_rej_o stays low for every other write.
- R7: When exactly one bit of a stored word (data or check) differs from a consistent codeword, a data read returns the corrected data with corr_err_o high and uncorr_err_o low.
- R8: When exactly two bits differ, a data read returns the raw stored data with uncorr_err_o high and corr_err_o low.
- R9: A pulse on init_start_i raises init_busy_o for exactly DEPTH cycles. During that time every word is set to zero data with check field 0, and bus requests are ignored. When the run ends, init_done_o goes high and stays high until the next start.
- R10: corr_err_o and uncorr_err_o are never high together, and are high only in a cycle where rvalid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 11 | Word address; bit 10 selects the check field |
| wdata_i | input | 32 | Write data (check field taken from bits 6:0) |
| ecc_en_i | input | 1 | ECC enable |
| diag_en_i | input | 1 | Diagnostic enable for check-field writes |
| init_start_i | input | 1 | Start pulse for hardware initialization |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read response strobe |
| corr_err_o | output | 1 | Corrected single-bit error on this read |
| uncorr_err_o | output | 1 | Uncorrectable double-bit error on this read |
| wr_rej_o | output | 1 | Blocked check-field write |
| init_busy_o | output | 1 | Initialization in progress |
| init_done_o | output | 1 | Initialization completed |

## Verification
The assertions relate each response to the request one cycle earlier. They therefore assume that req_i, we_i, addr_i, ecc_en_i and diag_en_i are stable and known at each rising edge after reset. The stimulus meets this by changing inputs only on the falling edge and by driving every input to a defined value from time zero.

The error-flag checks also assume that a word has been written or initialized before it is read as data. The bench meets this by writing every word it reads, or by running initialization first. Faults are created only through the port itself: ECC-off data writes, and diagnostic check-field writes.

// File: rtl/vec_ecc_pkg.sv
package vec_ecc_pkg;
  localparam int DW   = 32;
  localparam int HW   = 6;
  localparam int CW   = HW + 1;
  localparam int NPOS = DW + HW;

  // Hamming bits: data occupies the non-power-of-two positions 3..NPOS
  function automatic logic [HW-1:0] ham_bits(input logic [DW-1:0] d);
    logic [HW-1:0] h;
    logic [4:0]    k;
    h = '0;
    k = '0;
    for (int p = 3; p <= NPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int i = 0; i < HW; i++)
          if (((p >> i) & 1) == 1) h[i[2:0]] = h[i[2:0]] ^ d[k];
        k = k + 5'd1;
      end
    end
    return h;
  endfunction

  // Mask of the data bit sitting at Hamming position s (zero if none)
  function automatic logic [DW-1:0] pos_mask(input logic [HW-1:0] s);
    logic [DW-1:0] m;
    logic [4:0]    k;
    m = '0;
    k = '0;
    for (int p = 3; p <= NPOS; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (s == p[HW-1:0]) m[k] = 1'b1;
        k = k + 5'd1;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/vec_ecc_enc.sv
module vec_ecc_enc
  import vec_ecc_pkg::*;
(
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] chk_o
);
  logic [HW-1:0] ham;

  always_comb begin
    ham   = ham_bits(data_i);
    chk_o = {(^data_i) ^ (^ham), ham};
  end
endmodule

// File: rtl/vec_ecc_dec.sv
module vec_ecc_dec
  import vec_ecc_pkg::*;
(
  input  logic [DW-1:0] data_i,
  input  logic [CW-1:0] chk_i,
  output logic [DW-1:0] data_o,
  output logic          corr_o,
  output logic          uncorr_o
);
  logic [HW-1:0] syn;
  logic          par;
  logic [DW-1:0] flip;
  logic          syn_pow2;
  logic          hit;

  always_comb begin
    syn      = ham_bits(data_i) ^ chk_i[HW-1:0];
    par      = (^data_i) ^ (^chk_i);
    flip     = pos_mask(syn);
    hit      = |flip;
    syn_pow2 = (syn & (syn - 1'b1)) == '0; // includes zero
    corr_o   = par && (syn_pow2 || hit);
    uncorr_o = (syn != '0) && !(par && (syn_pow2 || hit));
    data_o   = (corr_o && hit) ? (data_i ^ flip) : data_i;
  end
endmodule

// File: rtl/vec_ecc_init.sv
module vec_ecc_init #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      idx_o  <= '0;
    end else if (busy_o) begin
      if (idx_o == LAST) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else begin
        idx_o <= idx_o + 1'b1;
      end
    end else if (start_i) begin
      busy_o <= 1'b1;
      done_o <= 1'b0;
      idx_o  <= '0;
    end
  end

  // R9: the run ends on the last word and leaves done set
  a_r9_last_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && idx_o == LAST |=> !busy_o && done_o);
  a_r9_done_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

// File: rtl/vec_ecc_ram.sv
module vec_ecc_ram
  import vec_ecc_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int ADDR_W    = 11,
  parameter int ALIAS_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              ecc_en_i,
  input  logic              diag_en_i,
  input  logic              init_start_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o,
  output logic              corr_err_o,
  output logic              uncorr_err_o,
  output logic              wr_rej_o,
  output logic              init_busy_o,
  output logic              init_done_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DW-1:0] data_mem [DEPTH];
  logic [CW-1:0] chk_mem  [DEPTH];

  logic [IDX_W-1:0] idx, init_idx, wr_idx;
  logic             acc, is_alias, data_we, chk_we, diag_ok, rd_req, rej;
  logic [DW-1:0]    enc_in, data_wval, dec_data;
  logic [CW-1:0]    enc_chk, chk_wval;
  logic             dec_corr, dec_uncorr;
  logic             unused_addr;

  assign unused_addr = ^addr_i;
  assign idx      = addr_i[IDX_W-1:0];
  assign is_alias = addr_i[ALIAS_BIT];
  assign acc      = req_i && !init_busy_o;
  assign diag_ok  = diag_en_i && ecc_en_i;
  assign rd_req   = acc && !we_i;
  assign rej      = acc && we_i && is_alias && !diag_ok;

  vec_ecc_init #(.DEPTH(DEPTH)) u_init (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (init_start_i),
    .busy_o  (init_busy_o),
    .done_o  (init_done_o),
    .idx_o   (init_idx)
  );

  always_comb begin
    wr_idx    = init_busy_o ? init_idx : idx;
    enc_in    = init_busy_o ? '0 : wdata_i;
    data_wval = enc_in;
    data_we   = init_busy_o || (acc && we_i && !is_alias);
    chk_we    = init_busy_o
             || (acc && we_i && !is_alias && ecc_en_i)
             || (acc && we_i && is_alias && diag_ok);
    chk_wval  = (!init_busy_o && is_alias) ? wdata_i[CW-1:0] : enc_chk;
  end

  vec_ecc_enc u_enc (
    .data_i (enc_in),
    .chk_o  (enc_chk)
  );

  vec_ecc_dec u_dec (
    .data_i   (data_mem[idx]),
    .chk_i    (chk_mem[idx]),
    .data_o   (dec_data),
    .corr_o   (dec_corr),
    .uncorr_o (dec_uncorr)
  );

  // storage has no reset: contents are undefined until written
  always_ff @(posedge clk_i) begin
    if (data_we) data_mem[wr_idx] <= data_wval;
    if (chk_we)  chk_mem[wr_idx]  <= chk_wval;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o      <= '0;
      rvalid_o     <= 1'b0;
      corr_err_o   <= 1'b0;
      uncorr_err_o <= 1'b0;
      wr_rej_o     <= 1'b0;
    end else begin
      rvalid_o     <= rd_req;
      wr_rej_o     <= rej;
      corr_err_o   <= rd_req && !is_alias && dec_corr;
      uncorr_err_o <= rd_req && !is_alias && dec_uncorr;
      if (rd_req) begin
        if (is_alias) rdata_o <= {{(DW-CW){1'b0}}, chk_mem[idx]};
        else          rdata_o <= dec_data;
      end
    end
  end

  // R2: check-field reads never flag errors
  a_r2_alias_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && $past(addr_i[ALIAS_BIT]) |-> !corr_err_o && !uncorr_err_o);
  // R6: rejection pulse follows exactly the blocked alias writes
  a_r6_rej_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i && we_i && addr_i[ALIAS_BIT] && !(diag_en_i && ecc_en_i) && !init_busy_o)
    |-> wr_rej_o);
  a_r6_rej_only_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rej_o |-> $past(req_i && we_i && addr_i[ALIAS_BIT]));
  // R9: bus ignored while the init engine runs
  a_r9_bus_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(init_busy_o) |-> !rvalid_o && !wr_rej_o);
  // R10: flags exclusive and tied to a response
  a_r10_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(corr_err_o && uncorr_err_o));
  a_r10_flags_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_err_o || uncorr_err_o) |-> rvalid_o);
  // R1: every accepted read gets a response next cycle
  a_r1_read_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_i && !we_i && !init_busy_o) |-> rvalid_o);
endmodule

// File: tb/vec_ecc_ram_tb.sv
module vec_ecc_ram_tb;
  localparam int DEPTH = 64;
  localparam logic [10:0] ALIAS = 11'h400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, ecc = 1'b0, diag = 1'b0, start = 1'b0;
  logic [10:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid, corr, uncorr, rej, busy, done;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vec_ecc_ram #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ecc_en_i(ecc), .diag_en_i(diag), .init_start_i(start),
    .rdata_o(rdata), .rvalid_o(rvalid), .corr_err_o(corr), .uncorr_err_o(uncorr),
    .wr_rej_o(rej), .init_busy_o(busy), .init_done_o(done)
  );

  // {data, bit to flip}
  localparam logic [36:0] VEC [8] = '{
    {32'h0000_0001, 5'd0},  {32'hFFFF_FFFF, 5'd31},
    {32'hA5A5_5A5A, 5'd7},  {32'h8000_0000, 5'd15},
    {32'h1234_5678, 5'd16}, {32'hDEAD_BEEF, 5'd3},
    {32'h0F0F_F0F0, 5'd24}, {32'h7FFF_0001, 5'd30}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d, input logic e, input logic g,
                    output logic r);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; ecc = e; diag = g;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    r = rej;
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] d, output logic v,
                    output logic c, output logic u);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata; v = rvalid; c = corr; u = uncorr;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, c0, c1;
    logic v, c, u, r;
    int cnt;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!rvalid && !rej && !busy && !done && !corr && !uncorr, "reset state", {26'd0, rvalid, rej, busy, done, corr, uncorr}, 32'd0);

    // R9: init engine
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (busy) begin
      req = (cnt == 3); we = 1'b0; addr = '0;
      @(negedge clk);
      cnt++;
      if (cnt == 4) check(!rvalid, "R9 read ignored while busy", {31'd0, rvalid}, 32'd0);
    end
    req = 1'b0;
    check(cnt == DEPTH, "R9 busy length", cnt, DEPTH);
    check(done, "R9 done set", {31'd0, done}, 32'd1);
    rd(11'd5, d, v, c, u);
    check(v && d == 32'd0 && !c && !u, "R9 zero data", d, 32'd0);
    rd(ALIAS | 11'd63, d, v, c, u);
    check(v && d == 32'd0, "R9 zero check field", d, 32'd0);

    // table walk: R1 R3 R4 R7
    for (int i = 0; i < 8; i++) begin
      logic [31:0] dv;
      logic [4:0]  b;
      dv = VEC[i][36:5];
      b  = VEC[i][4:0];
      wr(11'(i), dv, 1'b1, 1'b0, r);
      rd(11'(i), d, v, c, u);
      check(v && d == dv && !c && !u, "R1 R3 clean read", d, dv);
      rd(ALIAS | 11'(i), c0, v, c, u);
      wr(11'(i), dv ^ (32'd1 << b), 1'b0, 1'b0, r);
      rd(ALIAS | 11'(i), c1, v, c, u);
      check(c1 == c0, "R4 check field kept", c1, c0);
      rd(11'(i), d, v, c, u);
      check(v && d == dv && c && !u, "R7 data bit corrected", d, dv);
    end

    // R5 R2: check-field write through diag path
    wr(11'd20, 32'h600D_CAFE, 1'b1, 1'b0, r);
    rd(ALIAS | 11'd20, c0, v, c, u);
    check(v && c0[31:7] == '0 && !c && !u, "R2 alias read clean", c0, c0 & 32'h7F);
    wr(ALIAS | 11'd20, c0 ^ 32'h40, 1'b1, 1'b1, r);
    check(!r, "R6 allowed write not rejected", {31'd0, r}, 32'd0);
    rd(ALIAS | 11'd20, c1, v, c, u);
    check(c1 == (c0 ^ 32'h40) && !c && !u, "R5 check field written", c1, c0 ^ 32'h40);
    rd(11'd20, d, v, c, u);
    check(d == 32'h600D_CAFE && c && !u, "R5 R7 data kept, check bit corrected", d, 32'h600D_CAFE);
    wr(ALIAS | 11'd20, c0 ^ 32'h3, 1'b1, 1'b1, r);
    rd(11'd20, d, v, c, u);
    check(d == 32'h600D_CAFE && !c && u, "R8 double check-bit error", d, 32'h600D_CAFE);

    // R6: blocked alias writes
    wr(11'd22, 32'h1111_2222, 1'b1, 1'b0, r);
    rd(ALIAS | 11'd22, c0, v, c, u);
    wr(ALIAS | 11'd22, c0 ^ 32'h1, 1'b1, 1'b0, r);
    check(r, "R6 diag off rejected", {31'd0, r}, 32'd1);
    wr(ALIAS | 11'd22, c0 ^ 32'h1, 1'b0, 1'b1, r);
    check(r, "R6 ecc off rejected", {31'd0, r}, 32'd1);
    wr(ALIAS | 11'd22, c0 ^ 32'h1, 1'b0, 1'b0, r);
    check(r, "R6 both off rejected", {31'd0, r}, 32'd1);
    @(negedge clk);
    check(!rej, "R6 single-cycle pulse", {31'd0, rej}, 32'd0);
    rd(ALIAS | 11'd22, c1, v, c, u);
    check(c1 == c0, "R6 check field unchanged", c1, c0);
    rd(11'd22, d, v, c, u);
    check(d == 32'h1111_2222 && !c && !u, "R6 data unchanged", d, 32'h1111_2222);

    // R8: double data-bit error returns raw data
    wr(11'd21, 32'hCAFE_0000, 1'b1, 1'b0, r);
    wr(11'd21, 32'hCAFE_0003, 1'b0, 1'b0, r);
    rd(11'd21, d, v, c, u);
    check(d == 32'hCAFE_0003 && !c && u, "R8 double data error raw", d, 32'hCAFE_0003);
    rd(ALIAS | 11'd21, d, v, c, u);
    check(v && !c && !u, "R2 R10 alias read after fault", {30'd0, c, u}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule